// File: doc/BRIEF.md
# Split-Access Reload Timer

This block is a 12-bit down-counter with a reload register, reached by a CPU through two neighbouring byte locations on an 8-bit bus. Address 0 carries count bits 7:0, and address 1 carries bits 11:8 in its lower nibble. Software programs a period in two steps. It first writes the low byte, which is only staged. It then writes the high byte, which commits the full reload value and restarts the counter from it. The counter steps down once per strobe on the `tick` input, which comes from an external prescaler. With a typical 125 µs tick, the longest period is about half a second. Each time the count expires, `timeout` is raised for one cycle.

A read returns either the live count or the programmed reload value, selected by `show_reload`. A multi-byte read of a running count stays consistent. Reading the low byte copies count bits 11:8 into a holding latch, and the high-byte read that follows returns that latch instead of the live bits.

A small state machine drives the counting. `ST_HALT` is entered on reset and on any commit of a zero reload value; the count is frozen there. `ST_RUN` is entered on a commit of a nonzero value, and on any cycle after `ST_FIRE`. `ST_FIRE` is entered from `ST_RUN` or `ST_FIRE` when a tick arrives while the count is 1; the count then reloads and `timeout` is high for that state. A commit takes priority over any tick in the same cycle.

Top module: `tmr_split12`

## Requirements
- R1: After reset, the count and the reload value both read as 0, and `timeout` is low.
- R2: A write to address 0 only stages the byte. It changes neither the running count nor the reload value that reads back.
- R3: A write to address 1 commits {written bits 3:0, staged low byte} as the reload value. On the next clock edge the counter holds that same value.
- R4: Bits 7:4 written to address 1 are discarded. Bits 7:4 read from address 1 are always 0.
- R5: With `show_reload`=0, a read returns the count. The count drops by one per clock edge with `tick` high, and holds on edges with `tick` low.
- R6: With `show_reload`=0, a read of address 0 latches count bits 11:8. A later read of address 1 returns the latched nibble, not the live one.
- R7: With a nonzero reload value N and `tick` high on every edge, `timeout` is high once every N cycles. It is high for one cycle only, unless the next tick also expires the count. After each expiry the counter holds N, and `timeout` is never high unless `tick` was high on the previous edge.
- R8: With reload value 0, the count stays at 0 and `timeout` never rises.
- R9: A commit while the counter is running restarts the count from the new value. It overrides any tick in the same cycle.
- R10: With `show_reload`=1, a read returns the committed reload value: bits 7:0 at address 0 and bits 11:8 at address 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | 0 = low byte, 1 = high byte |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while a read is strobed, 0 otherwise |
| tick | input | 1 | Count-step strobe from the prescaler |
| show_reload | input | 1 | Read select: 0 = count, 1 = reload value |
| timeout | output | 1 | High in the cycle after the count expires |

## Verification
The bench uses the default 12-bit counter on an 8-bit bus. This keeps the whole reload space small enough to sweep. Every value from 0 to 4095 is committed and read back in both read modes. The periods of all reload values from 1 to 40, plus 256 and 4095, are timed with a tick on every cycle, so the one-tick case with back-to-back expiries and the longest period are both covered. Targeted sequences cover the nibble latch across a 0x100→0x0FF borrow, a staged byte during a run, and the zero-reload hold.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
    typedef enum logic [1:0] {
        ST_HALT = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIRE = 2'd2
    } tmr_state_e;
endpackage

// File: rtl/tmr_stage.sv
`timescale 1ns/1ps
module tmr_stage #(
    parameter int CNT_W = 12,
    parameter int BUS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lo_wr,
    input  logic             hi_wr,
    input  logic [BUS_W-1:0] wdata,
    output logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] reload_q
);
    localparam int HI_W = CNT_W - BUS_W;

    logic [BUS_W-1:0] lo_stage_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_stage_q <= '0;
        end else if (lo_wr) begin
            lo_stage_q <= wdata;
        end
    end

    always_comb begin
        load_val = {wdata[HI_W-1:0], lo_stage_q};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_q <= '0;
        end else if (hi_wr) begin
            reload_q <= load_val;
        end
    end
endmodule

// File: rtl/tmr_count.sv
`timescale 1ns/1ps
module tmr_count #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] reload_q,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt_q,
    output logic             timeout
);
    import tmr_pkg::*;

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    tmr_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HALT;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (load) begin
            cnt_d   = load_val;
            state_d = (load_val == '0) ? ST_HALT : ST_RUN;
        end else begin
            unique case (state_q)
                ST_HALT: begin
                    state_d = ST_HALT;
                end
                ST_RUN, ST_FIRE: begin
                    state_d = ST_RUN;
                    if (tick) begin
                        if (cnt_q == ONE) begin
                            cnt_d   = reload_q;
                            state_d = ST_FIRE;
                        end else begin
                            cnt_d = cnt_q - ONE;
                        end
                    end
                end
                default: begin
                    state_d = ST_HALT;
                end
            endcase
        end
    end

    always_comb begin
        timeout = (state_q == ST_FIRE);
    end
endmodule

// File: rtl/tmr_rdmux.sv
`timescale 1ns/1ps
module tmr_rdmux #(
    parameter int CNT_W = 12,
    parameter int BUS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lo_rd,
    input  logic             hi_rd,
    input  logic             show_reload,
    input  logic [CNT_W-1:0] cnt_q,
    input  logic [CNT_W-1:0] reload_q,
    output logic [BUS_W-1:0] rdata
);
    localparam int HI_W  = CNT_W - BUS_W;
    localparam int PAD_W = BUS_W - HI_W;

    logic [HI_W-1:0] nib_latch_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nib_latch_q <= '0;
        end else if (lo_rd) begin
            nib_latch_q <= cnt_q[CNT_W-1:BUS_W];
        end
    end

    always_comb begin
        rdata = '0;
        if (lo_rd) begin
            rdata = show_reload ? reload_q[BUS_W-1:0] : cnt_q[BUS_W-1:0];
        end else if (hi_rd) begin
            rdata = {{PAD_W{1'b0}},
                     show_reload ? reload_q[CNT_W-1:BUS_W] : nib_latch_q};
        end
    end
endmodule

// File: rtl/tmr_split12.sv
`timescale 1ns/1ps
module tmr_split12 #(
    parameter int CNT_W = 12,
    parameter int BUS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel,
    input  logic             bus_we,
    input  logic             bus_addr,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    input  logic             tick,
    input  logic             show_reload,
    output logic             timeout
);
    logic             lo_wr, hi_wr, lo_rd, hi_rd;
    logic [CNT_W-1:0] load_val;
    logic [CNT_W-1:0] reload_q;
    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        lo_wr = bus_sel &  bus_we & ~bus_addr;
        hi_wr = bus_sel &  bus_we &  bus_addr;
        lo_rd = bus_sel & ~bus_we & ~bus_addr;
        hi_rd = bus_sel & ~bus_we &  bus_addr;
    end

    tmr_stage #(.CNT_W(CNT_W), .BUS_W(BUS_W)) u_stage (
        .clk      (clk),
        .rst_n    (rst_n),
        .lo_wr    (lo_wr),
        .hi_wr    (hi_wr),
        .wdata    (bus_wdata),
        .load_val (load_val),
        .reload_q (reload_q)
    );

    tmr_count #(.CNT_W(CNT_W)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (hi_wr),
        .load_val (load_val),
        .reload_q (reload_q),
        .tick     (tick),
        .cnt_q    (cnt_q),
        .timeout  (timeout)
    );

    tmr_rdmux #(.CNT_W(CNT_W), .BUS_W(BUS_W)) u_rdmux (
        .clk         (clk),
        .rst_n       (rst_n),
        .lo_rd       (lo_rd),
        .hi_rd       (hi_rd),
        .show_reload (show_reload),
        .cnt_q       (cnt_q),
        .reload_q    (reload_q),
        .rdata       (bus_rdata)
    );
endmodule

// File: rtl/tmr_split12_chk.sv
`timescale 1ns/1ps
module tmr_split12_chk #(
    parameter int CNT_W = 12,
    parameter int BUS_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_sel,
    input logic             bus_we,
    input logic             bus_addr,
    input logic [BUS_W-1:0] bus_rdata,
    input logic             tick,
    input logic             timeout,
    input logic [CNT_W-1:0] reload_q,
    input logic [CNT_W-1:0] cnt_q
);
    localparam int HI_W = CNT_W - BUS_W;

    logic hi_wr_c;
    assign hi_wr_c = bus_sel & bus_we & bus_addr;

    // R2: only a high-byte write can change the committed value
    a_r2_stage_only: assert property (@(posedge clk) disable iff (!rst_n)
        !hi_wr_c |=> reload_q == $past(reload_q));

    // R3: the counter equals the committed value right after a commit
    a_r3_commit_loads: assert property (@(posedge clk) disable iff (!rst_n)
        hi_wr_c |=> cnt_q == reload_q);

    // R4: reserved high bits read as zero
    a_r4_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_we && bus_addr) |-> bus_rdata[BUS_W-1:HI_W] == '0);

    // R5: no tick and no commit means the count holds
    a_r5_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !hi_wr_c) |=> cnt_q == $past(cnt_q));

    // R7: an expiry is always caused by a tick
    a_r7_timeout_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> $past(tick));

    // R7: a running count never sits at zero
    a_r7_never_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0 && !hi_wr_c) |=> cnt_q != '0);

    // R8: zero reload never signals
    a_r8_zero_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (reload_q == '0) |-> !timeout);
endmodule

bind tmr_split12 tmr_split12_chk #(.CNT_W(CNT_W), .BUS_W(BUS_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .tick      (tick),
    .timeout   (timeout),
    .reload_q  (reload_q),
    .cnt_q     (cnt_q)
);

// File: tb/sim_tmr_split12.sv
`timescale 1ns/1ps
module sim_tmr_split12;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0;
    logic       bus_we = 1'b0;
    logic       bus_addr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       tick = 1'b0;
    logic       show_reload = 1'b0;
    logic       timeout;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    tmr_split12 u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tick(tick), .show_reload(show_reload), .timeout(timeout)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic load12(input logic [11:0] v);
        wr(1'b0, v[7:0]);
        wr(1'b1, {4'h0, v[11:8]});
    endtask

    task automatic rd12(input logic test, output logic [11:0] v);
        logic [7:0] lo, hi;
        show_reload = test;
        rd(1'b0, lo);
        rd(1'b1, hi);
        v = {hi[3:0], lo};
    endtask

    task automatic run_ticks(input int n);
        @(negedge clk);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic period_test(input int n);
        int c1, c2;
        logic [11:0] v;
        load12(12'(n));
        tick = 1'b1;
        c1 = 0;
        do begin @(negedge clk); c1++; end while (!timeout && c1 < 5000);
        chk("R7 first period", c1, n);
        c2 = 0;
        do begin @(negedge clk); c2++; end while (!timeout && c2 < 5000);
        chk("R7 second period", c2, n);
        tick = 1'b0;
        @(negedge clk);
        chk("R7 pulse ends", timeout, 0);
        rd12(1'b0, v);
        chk("R7 reloaded count", v, n);
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=expired exp=done");
        finish_run();
    end

    initial begin
        logic [11:0] v;
        logic [7:0]  b;
        int hits;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk("R1 timeout", timeout, 0);
        rd12(1'b0, v); chk("R1 count", v, 0);
        rd12(1'b1, v); chk("R1 reload", v, 0);

        // R3, R10: sweep every reload value in both read modes
        for (int i = 0; i < 4096; i++) begin
            load12(12'(i));
            rd12(1'b1, v); chk("R10 reload readback", v, i);
            rd12(1'b0, v); chk("R3 count after commit", v, i);
        end

        // R5: counting and holding
        load12(12'h123);
        run_ticks(5);
        rd12(1'b0, v); chk("R5 count after 5 ticks", v, 12'h11E);
        repeat (10) @(negedge clk);
        rd12(1'b0, v); chk("R5 hold without tick", v, 12'h11E);

        // R2: staging leaves count and reload alone
        wr(1'b0, 8'h55);
        rd12(1'b0, v); chk("R2 count untouched", v, 12'h11E);
        rd12(1'b1, v); chk("R2 reload untouched", v, 12'h123);

        // R9, R3: commit during run restarts from the new value
        wr(1'b1, 8'h02);
        rd12(1'b0, v); chk("R9 restart count", v, 12'h255);
        rd12(1'b1, v); chk("R3 committed value", v, 12'h255);

        // R9: commit in the same cycle as a tick wins
        tick = 1'b1;
        wr(1'b0, 8'h40);
        wr(1'b1, 8'h03);
        tick = 1'b0;
        rd12(1'b0, v); chk("R9 commit over tick", v, 12'h340);

        // R4: reserved nibble discarded and read as zero
        wr(1'b0, 8'h34);
        wr(1'b1, 8'hF7);
        show_reload = 1'b1;
        rd(1'b1, b); chk("R4 reload high byte", b, 8'h07);
        show_reload = 1'b0;
        rd(1'b0, b);
        rd(1'b1, b); chk("R4 count high byte", b, 8'h07);

        // R6: latch across a borrow 0x100 -> 0x0FF
        load12(12'h100);
        show_reload = 1'b0;
        rd(1'b0, b); chk("R6 low before", b, 8'h00);
        run_ticks(1);
        rd(1'b1, b); chk("R6 latched high nibble", b, 8'h01);
        rd(1'b0, b); chk("R6 live low", b, 8'hFF);
        rd(1'b1, b); chk("R6 fresh high nibble", b, 8'h00);

        // R7: periods
        for (int n = 1; n <= 40; n++) period_test(n);
        period_test(256);
        period_test(4095);

        // R8: zero reload holds silently
        load12(12'h000);
        tick = 1'b1;
        hits = 0;
        repeat (50) begin @(negedge clk); if (timeout) hits++; end
        tick = 1'b0;
        chk("R8 no timeout", hits, 0);
        rd12(1'b0, v); chk("R8 count held", v, 0);

        finish_run();
    end
endmodule